// File: doc/BRIEF.md
# Decoded Line Capture Latch

This block sits between a real-time line decoder and a slow register port. The decoder produces one decoded packet per video line: a parallel payload word, a standard identifier and a one-cycle valid strobe. A host that reads over a slow serial register bus cannot keep up with that rate. Without help it could read a buffer while the next line is overwriting it.

The block gives the host one-shot capture buffers. There is one dedicated buffer for each of closed caption, copy-generation management and widescreen signalling. A fourth, shared buffer loads whichever standard a 3-bit select register names. To use a buffer, the host writes its self-clearing clear bit to arm it. The host then polls the sticky available bit in the status register and reads the bytes. After one packet is latched, the buffer freezes until it is armed again. The shared buffer also needs its select value written before it is armed.

Top module: `pkt_capture_bank`

## Requirements
- R1: After reset every buffer is disarmed, with its available bit at 0 and its data at zero. The select register reads 0.
- R2: A write to the control register at address 0x40 arms a buffer for each data bit set to 1: bit0 closed caption, bit1 copy-management, bit2 widescreen, bit3 shared. The control register always reads back 0.
- R3: Arming a buffer clears its available bit on the next cycle.
- R4: An armed buffer captures the first packet whose valid strobe and matching standard id arrive in the same cycle. Its available bit is 1 from the following cycle.
- R5: While a buffer's available bit is 1, later matching packets change neither its data nor its available bit.
- R6: A packet whose standard id does not match a buffer, or that arrives while the buffer is not armed, has no effect on that buffer.
- R7: The select register at address 0x41 holds 3 bits, and the shared buffer matches the standard id equal to its value. Id codes: 0 program guide, 1 programme system, 2 programme delivery (PDC), 3 time code, 4 copy-management type B, 5 closed caption, 6 copy-management, 7 widescreen.
- R8: The shared buffer's payload bytes read at addresses 0x47 to 0x53. Address 0x47+j returns payload bits 8j+7:8j, so 0x4A to 0x53 return bits 31:24 up to 103:96.
- R9: Dedicated buffer k (0 closed caption id 5, 1 copy-management id 6, 2 widescreen id 7) holds payload bits 23:0. Address 0x30+4k+j returns bits 8j+7:8j for j from 0 to 2.
- R10: When an arming write and a matching packet arrive in the same cycle, the arming wins and that packet is dropped.
- R11: A new select value applies from the cycle after its write. A packet that has already been captured stays until the next arming.
- R12: The status register at address 0x42 returns the available bits in bits 3:0, in the same order as the control bits. Reading it changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_valid | input | 1 | One-cycle strobe for a completed decoded packet |
| pkt_std | input | 3 | Standard id of the packet |
| pkt_data | input | 104 | Decoded packet payload |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address for reads and writes |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |

## Verification
The assertions check the per-cycle rules of every capture slot on every clock: arming clears the available bit, a capture copies the payload and sets the bit, and a frozen or disarmed slot holds its data. They also check that the select register changes only on its own write and that the control address reads zero. Only the bench scenarios can show the end-to-end behaviour. These are the address-to-byte mapping, the steering of the shared buffer by the select value and by later changes to it, the arm-versus-capture collision, and the sequence of status values across a run of mixed packets.

// File: rtl/pcl_pkg.sv
package pcl_pkg;

    localparam int STD_W     = 3;
    localparam int PAYLOAD_W = 104;
    localparam int ADDR_W    = 8;
    localparam int DATA_W    = 8;
    localparam int NUM_DED   = 3;
    localparam int NUM_BUF   = NUM_DED + 1;
    localparam int DED_BYTES = 3;
    localparam int DED_W     = DED_BYTES * DATA_W;
    localparam int SH_BYTES  = PAYLOAD_W / DATA_W;
    localparam int SH_IDX    = NUM_DED;

    localparam logic [ADDR_W-1:0] ADR_CTRL     = 8'h40;
    localparam logic [ADDR_W-1:0] ADR_SEL      = 8'h41;
    localparam logic [ADDR_W-1:0] ADR_STAT     = 8'h42;
    localparam logic [ADDR_W-1:0] ADR_DED_BASE = 8'h30;
    localparam int                DED_STRIDE   = 4;
    localparam logic [ADDR_W-1:0] ADR_SH_BASE  = 8'h47;

    typedef enum logic [STD_W-1:0] {
        STD_GUIDE = 3'd0,
        STD_PSYS  = 3'd1,
        STD_PDC   = 3'd2,
        STD_TCODE = 3'd3,
        STD_CGMSB = 3'd4,
        STD_CC    = 3'd5,
        STD_CGMS  = 3'd6,
        STD_WSS   = 3'd7
    } std_id_e;

    typedef struct packed {
        logic                 valid;
        logic [STD_W-1:0]     id;
        logic [PAYLOAD_W-1:0] data;
    } pkt_t;

    function automatic logic [STD_W-1:0] ded_std(input int k);
        return STD_W'(int'(STD_CC) + k);
    endfunction

    function automatic logic [ADDR_W-1:0] ded_addr(input int k, input int j);
        return ADDR_W'(int'(ADR_DED_BASE) + k * DED_STRIDE + j);
    endfunction

    function automatic logic [ADDR_W-1:0] sh_addr(input int j);
        return ADDR_W'(int'(ADR_SH_BASE) + j);
    endfunction

endpackage

// File: rtl/pcl_slot.sv
module pcl_slot #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         take,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         avail
);

    logic armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
            avail <= 1'b0;
            dout  <= '0;
        end else if (clr) begin
            armed <= 1'b1;
            avail <= 1'b0;
        end else if (armed && take) begin
            dout  <= din;
            avail <= 1'b1;
            armed <= 1'b0;
        end
    end

    // R3
    clear_drops_avail_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> !avail);

    // R4
    capture_sets_avail_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && take && !clr) |=> (avail && dout == $past(din)));

    // R5
    frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (avail && !clr) |=> (avail && $stable(dout)));

    // R6
    disarmed_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!armed && !clr) |=> $stable(dout));

endmodule

// File: rtl/pcl_regs.sv
module pcl_regs
    import pcl_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [NUM_BUF-1:0] clr,
    output logic [STD_W-1:0]   sel_q
);

    logic wr_ctrl;
    logic wr_sel;
    logic unused_wbits;

    assign wr_ctrl      = reg_wr && (reg_addr == ADR_CTRL);
    assign wr_sel       = reg_wr && (reg_addr == ADR_SEL);
    assign clr          = wr_ctrl ? reg_wdata[NUM_BUF-1:0] : '0;
    assign unused_wbits = ^reg_wdata[DATA_W-1:NUM_BUF];

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
        end else if (wr_sel) begin
            sel_q <= reg_wdata[STD_W-1:0];
        end
    end

    // R7
    sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr && reg_addr == ADR_SEL) |=> $stable(sel_q));

endmodule

// File: rtl/pcl_rdmux.sv
module pcl_rdmux
    import pcl_pkg::*;
(
    input  logic [ADDR_W-1:0]             reg_addr,
    input  logic [STD_W-1:0]              sel_q,
    input  logic [NUM_BUF-1:0]            avail,
    input  logic [NUM_DED-1:0][DED_W-1:0] ded_data,
    input  logic [PAYLOAD_W-1:0]          sh_data,
    output logic [DATA_W-1:0]             reg_rdata
);

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADR_SEL) begin
            reg_rdata = DATA_W'(sel_q);
        end
        if (reg_addr == ADR_STAT) begin
            reg_rdata = DATA_W'(avail);
        end
        for (int k = 0; k < NUM_DED; k++) begin
            for (int j = 0; j < DED_BYTES; j++) begin
                if (reg_addr == ded_addr(k, j)) begin
                    reg_rdata = ded_data[k][j*DATA_W +: DATA_W];
                end
            end
        end
        for (int j = 0; j < SH_BYTES; j++) begin
            if (reg_addr == sh_addr(j)) begin
                reg_rdata = sh_data[j*DATA_W +: DATA_W];
            end
        end
    end

endmodule

// File: rtl/pkt_capture_bank.sv
module pkt_capture_bank
    import pcl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 pkt_valid,
    input  logic [STD_W-1:0]     pkt_std,
    input  logic [PAYLOAD_W-1:0] pkt_data,
    input  logic                 reg_wr,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata
);

    pkt_t                          pkt;
    logic [NUM_BUF-1:0]            clr;
    logic [NUM_BUF-1:0]            avail;
    logic [STD_W-1:0]              sel_q;
    logic [NUM_DED-1:0][DED_W-1:0] ded_data;
    logic [PAYLOAD_W-1:0]          sh_data;

    assign pkt.valid = pkt_valid;
    assign pkt.id    = pkt_std;
    assign pkt.data  = pkt_data;

    pcl_regs i_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .clr       (clr),
        .sel_q     (sel_q)
    );

    for (genvar k = 0; k < NUM_DED; k++) begin : g_ded
        logic hit;
        assign hit = pkt.valid && (pkt.id == ded_std(k));

        pcl_slot #(.W(DED_W)) i_slot (
            .clk   (clk),
            .rst   (rst),
            .clr   (clr[k]),
            .take  (hit),
            .din   (pkt.data[DED_W-1:0]),
            .dout  (ded_data[k]),
            .avail (avail[k])
        );
    end

    logic sh_hit;
    assign sh_hit = pkt.valid && (pkt.id == sel_q);

    pcl_slot #(.W(PAYLOAD_W)) i_shared (
        .clk   (clk),
        .rst   (rst),
        .clr   (clr[SH_IDX]),
        .take  (sh_hit),
        .din   (pkt.data),
        .dout  (sh_data),
        .avail (avail[SH_IDX])
    );

    pcl_rdmux i_rdmux (
        .reg_addr  (reg_addr),
        .sel_q     (sel_q),
        .avail     (avail),
        .ded_data  (ded_data),
        .sh_data   (sh_data),
        .reg_rdata (reg_rdata)
    );

    // R2
    ctrl_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == ADR_CTRL) |-> (reg_rdata == '0));

    // R10
    arm_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (clr[SH_IDX] && sh_hit) |=> !avail[SH_IDX]);

endmodule

// File: tb/test_pkt_capture_bank.sv
module test_pkt_capture_bank;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         pkt_valid = 1'b0;
    logic [2:0]   pkt_std = '0;
    logic [103:0] pkt_data = '0;
    logic         reg_wr = 1'b0;
    logic [7:0]   reg_addr = '0;
    logic [7:0]   reg_wdata = '0;
    logic [7:0]   reg_rdata;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    pkt_capture_bank i_pkt_capture_bank (
        .clk       (clk),
        .rst       (rst),
        .pkt_valid (pkt_valid),
        .pkt_std   (pkt_std),
        .pkt_data  (pkt_data),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata)
    );

    localparam logic [7:0] A_CTRL = 8'h40;
    localparam logic [7:0] A_SEL  = 8'h41;
    localparam logic [7:0] A_STAT = 8'h42;

    typedef struct packed {
        logic [3:0] clr;
        logic [2:0] sel;
        logic [2:0] std;
        logic [7:0] tag;
        logic [3:0] stat;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{4'h0, 3'd0, 3'd5, 8'h11, 4'h0},
        '{4'h1, 3'd0, 3'd6, 8'h22, 4'h0},
        '{4'h0, 3'd0, 3'd5, 8'h33, 4'h1},
        '{4'h0, 3'd0, 3'd5, 8'h44, 4'h1},
        '{4'h8, 3'd2, 3'd2, 8'h55, 4'h9},
        '{4'h6, 3'd2, 3'd7, 8'h66, 4'hD},
        '{4'h0, 3'd2, 3'd6, 8'h77, 4'hF}
    };

    function automatic logic [103:0] mk(input logic [7:0] tag);
        logic [103:0] p;
        for (int i = 0; i < 13; i++) p[i*8 +: 8] = 8'(tag + 8'(i));
        return p;
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic send(input logic [2:0] s, input logic [7:0] tag);
        @(negedge clk);
        pkt_valid = 1'b1; pkt_std = s; pkt_data = mk(tag);
        @(negedge clk);
        pkt_valid = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic [7:0] v2;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(A_STAT, v); chk("R1 status", v, 8'h00);
        rd(A_SEL, v);  chk("R1 select", v, 8'h00);
        rd(8'h4A, v);  chk("R1 shared byte", v, 8'h00);
        rd(8'h30, v);  chk("R1 cc byte", v, 8'h00);

        // R4 R5 R6 R7 R12 vector table
        for (int n = 0; n < NV; n++) begin
            wr(A_SEL, 8'(VECS[n].sel));
            if (VECS[n].clr != 4'h0) wr(A_CTRL, 8'(VECS[n].clr));
            send(VECS[n].std, VECS[n].tag);
            rd(A_STAT, v);
            chk($sformatf("R4/R5/R6 vector %0d status", n), v, 8'(VECS[n].stat));
        end

        // R9 dedicated bytes
        for (int j = 0; j < 3; j++) begin
            rd(8'(8'h30 + j), v); chk("R9 cc byte", v, 8'(8'h33 + j));
            rd(8'(8'h34 + j), v); chk("R9 cgms byte", v, 8'(8'h77 + j));
            rd(8'(8'h38 + j), v); chk("R9 wss byte", v, 8'(8'h66 + j));
        end
        // R8 shared bytes
        for (int j = 0; j < 13; j++) begin
            rd(8'(8'h47 + j), v); chk("R8 shared byte", v, 8'(8'h55 + j));
        end

        // R2 control reads zero
        rd(A_CTRL, v); chk("R2 ctrl readback", v, 8'h00);

        // R10 arm and matching packet in one cycle
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = A_CTRL; reg_wdata = 8'h08;
        pkt_valid = 1'b1; pkt_std = 3'd2; pkt_data = mk(8'h88);
        @(negedge clk);
        reg_wr = 1'b0; pkt_valid = 1'b0;
        rd(A_STAT, v); chk("R10 shared not captured", v, 8'h07);
        rd(8'h4A, v);  chk("R3 data kept until capture", v, 8'h58);
        send(3'd2, 8'h90);
        rd(A_STAT, v); chk("R10 next packet captured", v, 8'h0F);
        rd(8'h4A, v);  chk("R10 shared byte", v, 8'h93);

        // R11 select change while armed
        wr(A_CTRL, 8'h08);
        rd(A_STAT, v); chk("R3 arm clears avail", v, 8'h07);
        wr(A_SEL, 8'h04);
        send(3'd2, 8'hA0);
        rd(A_STAT, v); chk("R11 old select ignored", v, 8'h07);
        send(3'd4, 8'hB0);
        rd(A_STAT, v); chk("R11 new select captured", v, 8'h0F);
        wr(A_SEL, 8'h01);
        send(3'd1, 8'hC0);
        rd(8'h4A, v);  chk("R11 captured data kept", v, 8'hB3);
        rd(A_SEL, v);  chk("R7 select readback", v, 8'h01);

        // R12 status read has no side effects
        rd(A_STAT, v);
        rd(A_STAT, v2);
        chk("R12 status repeat", v2, v);
        rd(8'h30, v);  chk("R12 cc data after status reads", v, 8'h33);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule